// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Processor Core

This block is a 32-bit processor core that fetches, decodes and fully executes one instruction every clock cycle. A program counter addresses a word-organised instruction store. The fetched word is split into its fields and decoded by a main control decoder and a second decoder that picks the ALU operation. A two-read, one-write register file of 32 entries feeds a 32-bit ALU. A word-organised data store serves loads and stores. The program counter, the register file and the data store change state only at the rising clock edge that closes each instruction.

The supported instructions are load word, store word, branch-if-equal, the register forms add, sub, and, or and set-less-than, and the immediate forms add, and, or and set-less-than. The ALU decoder has four modes. The first adds, for address generation. The second subtracts, for the branch compare. The third takes the operation from the function field. The fourth takes it from the primary opcode, so the immediate forms need no function field.

A testbench or boot agent loads both stores through a preload write port, normally while reset is held. Debug taps give the program counter, any register selected by number, and any data-store word selected by byte address. Both stores index words with address bits [MEM_AW+1:2]. The default MEM_AW of 10 gives 1024 words per store, and MEM_AW = 16 gives the full 65536-word store.

Top module: `scp_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and all 32 registers become 0. After reset, a non-branching instruction advances the PC by 4 at each rising edge.
- R2: The primary opcode in bits 31:26 is decoded as: 000000 register form, 100011 load word, 101011 store word, 000100 branch-if-equal, 001000 add-immediate, 001100 and-immediate, 001101 or-immediate, 001010 set-less-than-immediate.
- R3: A register-form instruction writes rd (bits 15:11) with rs op rt. The operation comes from the function field in bits 5:0: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 set-less-than.
- R4: An immediate-form instruction writes rt (bits 20:16) with rs op imm. Here imm is the 16-bit field in bits 15:0, sign-extended to 32 bits, for all four immediate forms including or-immediate.
- R5: Set-less-than, in both register and immediate forms, compares as signed 32-bit values and writes exactly 1 or 0.
- R6: Load and store use the byte address rs + sign-extended imm, and access the data word at address bits [MEM_AW+1:2]. A load writes that word to rt. A store writes rt to that word at the rising edge, and the write can be read back on the next cycle.
- R7: Branch-if-equal sets the next PC to PC + 4 + (sign-extended imm << 2) when rs equals rt, and to PC + 4 otherwise. It writes no register.
- R8: Register 0 always reads as 0. Writes addressed to register 0 have no effect.
- R9: An opcode outside the set in R2 writes no register and no memory, and the PC advances by 4.
- R10: When `pl_imem_we` or `pl_dmem_we` is high, `pl_data` is written into the instruction or data store at the word given by `pl_addr[MEM_AW+1:2]`. The taps `dbg_pc`, `dbg_reg_data` (register `dbg_reg_sel`) and `dbg_mem_data` (data word at `dbg_mem_addr`) read combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes at the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pl_imem_we | input | 1 | Preload write enable for the instruction store |
| pl_dmem_we | input | 1 | Preload write enable for the data store (wins over a store instruction) |
| pl_addr | input | 32 | Preload byte address |
| pl_data | input | 32 | Preload write data |
| dbg_reg_sel | input | 5 | Register number shown on `dbg_reg_data` |
| dbg_mem_addr | input | 32 | Data-store byte address shown on `dbg_mem_data` |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg_data | output | 32 | Contents of the selected register |
| dbg_mem_data | output | 32 | Contents of the selected data word |

## Verification
The assertions assume that the preload port is used only while reset is held. They also assume that every fetched word has been preloaded, so that the decoders never see unknown bits. The bench loads the whole program and the data word used by the preload check during reset, and it closes the program with a branch to itself. The core therefore always fetches defined words after reset is released. The sweep reaches both branch outcomes by forcing one operand pair in four to be equal. It also inserts two undecodable opcodes, so that the no-op path is covered without leaving the defined program.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int XLEN  = 32;
    localparam int NREGS = 32;
    localparam int RIDX  = $clog2(NREGS);

    // primary opcodes, bits 31:26
    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] OPC_LDW  = 6'b100011;
    localparam logic [5:0] OPC_STW  = 6'b101011;
    localparam logic [5:0] OPC_BEQ  = 6'b000100;
    localparam logic [5:0] OPC_ADDI = 6'b001000;
    localparam logic [5:0] OPC_ANDI = 6'b001100;
    localparam logic [5:0] OPC_ORI  = 6'b001101;
    localparam logic [5:0] OPC_SLTI = 6'b001010;

    // function field, bits 5:0
    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        AMODE_ADD = 2'b00,
        AMODE_SUB = 2'b01,
        AMODE_FN  = 2'b10,
        AMODE_OPC = 2'b11
    } amode_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } aluctl_e;

    typedef struct packed {
        logic   dst_rd;
        logic   b_is_imm;
        logic   wb_from_mem;
        logic   rf_we;
        logic   mem_rd;
        logic   mem_we;
        logic   is_branch;
        amode_e amode;
    } ctrl_t;

    typedef struct packed {
        logic [5:0]      opc;
        logic [RIDX-1:0] rs;
        logic [RIDX-1:0] rt;
        logic [RIDX-1:0] rd;
        logic [4:0]      shamt;
        logic [5:0]      fn;
    } insn_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [15:0] imm_of(input insn_t i);
        return {i.rd, i.shamt, i.fn};
    endfunction

    function automatic logic opc_known(input logic [5:0] o);
        return (o == OPC_REG) || (o == OPC_LDW) || (o == OPC_STW) ||
               (o == OPC_BEQ) || (o == OPC_ADDI) || (o == OPC_ANDI) ||
               (o == OPC_ORI) || (o == OPC_SLTI);
    endfunction

endpackage

// File: rtl/scp_main_ctrl.sv
module scp_main_ctrl
    import scp_pkg::*;
(
    input  logic [5:0] opc,
    output ctrl_t      ctl
);

    always_comb begin
        ctl = '0;
        ctl.amode = AMODE_ADD;
        case (opc)
            OPC_REG: begin
                ctl.dst_rd = 1'b1;
                ctl.rf_we  = 1'b1;
                ctl.amode  = AMODE_FN;
            end
            OPC_LDW: begin
                ctl.b_is_imm    = 1'b1;
                ctl.wb_from_mem = 1'b1;
                ctl.rf_we       = 1'b1;
                ctl.mem_rd      = 1'b1;
                ctl.amode       = AMODE_ADD;
            end
            OPC_STW: begin
                ctl.b_is_imm = 1'b1;
                ctl.mem_we   = 1'b1;
                ctl.amode    = AMODE_ADD;
            end
            OPC_BEQ: begin
                ctl.is_branch = 1'b1;
                ctl.amode     = AMODE_SUB;
            end
            OPC_ADDI, OPC_ANDI, OPC_ORI, OPC_SLTI: begin
                ctl.b_is_imm = 1'b1;
                ctl.rf_we    = 1'b1;
                ctl.amode    = AMODE_OPC;
            end
            default: ctl = '0;   // undecodable: behaves as a no-op
        endcase
    end

endmodule

// File: rtl/scp_alu_ctrl.sv
module scp_alu_ctrl
    import scp_pkg::*;
(
    input  amode_e     amode,
    input  logic [5:0] opc,
    input  logic [5:0] fn,
    output aluctl_e    op
);

    function automatic aluctl_e from_fn(input logic [5:0] f);
        case (f)
            FN_ADD:  return ALU_ADD;
            FN_SUB:  return ALU_SUB;
            FN_AND:  return ALU_AND;
            FN_OR:   return ALU_OR;
            FN_SLT:  return ALU_SLT;
            default: return ALU_ADD;
        endcase
    endfunction

    function automatic aluctl_e from_opc(input logic [5:0] o);
        case (o)
            OPC_ADDI: return ALU_ADD;
            OPC_ANDI: return ALU_AND;
            OPC_ORI:  return ALU_OR;
            OPC_SLTI: return ALU_SLT;
            default:  return ALU_ADD;
        endcase
    endfunction

    always_comb begin
        case (amode)
            AMODE_ADD: op = ALU_ADD;
            AMODE_SUB: op = ALU_SUB;
            AMODE_FN:  op = from_fn(fn);
            default:   op = from_opc(opc);
        endcase
    end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
    import scp_pkg::*;
#(
    parameter int DW = XLEN
) (
    input  aluctl_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   y,
    output logic            zero
);

    always_comb begin
        case (op)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile
    import scp_pkg::*;
#(
    parameter int NR = NREGS,
    parameter int DW = XLEN,
    localparam int AW = $clog2(NR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    input  logic [AW-1:0] ra_dbg,
    output logic [DW-1:0] rd_a,
    output logic [DW-1:0] rd_b,
    output logic [DW-1:0] rd_dbg,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] regs [NR];

    function automatic logic [DW-1:0] rd_port(input logic [AW-1:0] idx,
                                               input logic [DW-1:0] val);
        return (idx == '0) ? '0 : val;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NR; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd_a   = rd_port(ra_a,   regs[ra_a]);
    assign rd_b   = rd_port(ra_b,   regs[ra_b]);
    assign rd_dbg = rd_port(ra_dbg, regs[ra_dbg]);

    // R8: the storage behind register 0 never takes a value
    p_zero_reg_held_r8: assert property (@(posedge clk) disable iff (rst)
        (we && (wa == '0)) |=> (regs[0] == '0));

endmodule

// File: rtl/scp_wordmem.sv
module scp_wordmem
    import scp_pkg::*;
#(
    parameter int AW  = 10,
    parameter int DW  = XLEN,
    parameter int NRD = 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     wa,
    input  logic [DW-1:0]     wd,
    input  logic [NRD*AW-1:0] ra,
    output logic [NRD*DW-1:0] rd
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rport
        assign rd[p*DW +: DW] = mem[ra[p*AW +: AW]];
    end

endmodule

// File: rtl/scp_core.sv
module scp_core
    import scp_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pl_imem_we,
    input  logic        pl_dmem_we,
    input  logic [31:0] pl_addr,
    input  logic [31:0] pl_data,
    input  logic [4:0]  dbg_reg_sel,
    input  logic [31:0] dbg_mem_addr,
    output logic [31:0] dbg_pc,
    output logic [31:0] dbg_reg_data,
    output logic [31:0] dbg_mem_data
);

    localparam int IX_HI = MEM_AW + 1;

    logic [XLEN-1:0] pc_q, pc_nxt, pc_inc, pc_br;
    insn_t           ins;
    ctrl_t           ctl;
    aluctl_e         aop;
    logic [XLEN-1:0] rs_val, rt_val, imm_x, alu_b, alu_y, mem_q, wb_val;
    logic            alu_z;
    logic [RIDX-1:0] dst;
    logic            take_br;

    // instruction fetch
    logic [XLEN-1:0] ins_word;
    scp_wordmem #(.AW(MEM_AW), .DW(XLEN), .NRD(1)) u_imem (
        .clk (clk),
        .we  (pl_imem_we),
        .wa  (pl_addr[IX_HI:2]),
        .wd  (pl_data),
        .ra  (pc_q[IX_HI:2]),
        .rd  (ins_word)
    );
    assign ins = insn_t'(ins_word);

    // decode
    scp_main_ctrl u_mctl (.opc(ins.opc), .ctl(ctl));
    scp_alu_ctrl  u_actl (.amode(ctl.amode), .opc(ins.opc), .fn(ins.fn), .op(aop));

    assign imm_x = sext16(imm_of(ins));
    assign dst   = ctl.dst_rd ? ins.rd : ins.rt;

    scp_regfile #(.NR(NREGS), .DW(XLEN)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_a   (ins.rs),
        .ra_b   (ins.rt),
        .ra_dbg (dbg_reg_sel),
        .rd_a   (rs_val),
        .rd_b   (rt_val),
        .rd_dbg (dbg_reg_data),
        .we     (ctl.rf_we && !rst),
        .wa     (dst),
        .wd     (wb_val)
    );

    // execute
    assign alu_b = ctl.b_is_imm ? imm_x : rt_val;
    scp_alu #(.DW(XLEN)) u_alu (.op(aop), .a(rs_val), .b(alu_b), .y(alu_y), .zero(alu_z));

    // data store: preload write takes priority over a store instruction
    logic          dm_we;
    logic [MEM_AW-1:0] dm_wa;
    logic [XLEN-1:0]   dm_wd;
    logic [2*XLEN-1:0] dm_rd;
    assign dm_we = pl_dmem_we || (ctl.mem_we && !rst);
    assign dm_wa = pl_dmem_we ? pl_addr[IX_HI:2] : alu_y[IX_HI:2];
    assign dm_wd = pl_dmem_we ? pl_data : rt_val;

    scp_wordmem #(.AW(MEM_AW), .DW(XLEN), .NRD(2)) u_dmem (
        .clk (clk),
        .we  (dm_we),
        .wa  (dm_wa),
        .wd  (dm_wd),
        .ra  ({dbg_mem_addr[IX_HI:2], alu_y[IX_HI:2]}),
        .rd  (dm_rd)
    );
    assign mem_q        = dm_rd[XLEN-1:0];
    assign dbg_mem_data = dm_rd[2*XLEN-1:XLEN];

    assign wb_val = ctl.wb_from_mem ? mem_q : alu_y;

    // next PC
    assign pc_inc  = pc_q + 32'd4;
    assign pc_br   = pc_inc + {imm_x[XLEN-3:0], 2'b00};
    assign take_br = ctl.is_branch && alu_z;
    assign pc_nxt  = take_br ? pc_br : pc_inc;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_nxt;
    end

    assign dbg_pc = pc_q;

    logic unused_sink;
    assign unused_sink = ^{ctl.mem_rd, pl_addr[31:IX_HI+1], pl_addr[1:0],
                           dbg_mem_addr[31:IX_HI+1], dbg_mem_addr[1:0]};

    // R1: the PC stays word aligned
    p_pc_aligned_r1: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00);

    // R1, R9: without a taken branch the PC steps by one word
    p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
        !take_br |=> pc_q == $past(pc_q) + 32'd4);

    // R7: a taken branch lands on the offset target
    p_branch_target_r7: assert property (@(posedge clk) disable iff (rst)
        take_br |=> pc_q == $past(pc_q) + 32'd4 + {$past(imm_x[XLEN-3:0]), 2'b00});

    // R9: an undecodable opcode touches no state
    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !opc_known(ins.opc) |-> !ctl.rf_we && !ctl.mem_we && !ctl.is_branch);

    // R2: memory read, memory write and branch are mutually exclusive
    p_ctrl_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl.mem_rd, ctl.mem_we, ctl.is_branch}));

    // R6: address generation always adds
    p_addr_adds_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl.mem_rd || ctl.mem_we) |-> (alu_y == rs_val + imm_x));

    // R5: set-less-than yields a single bit
    p_slt_bool_r5: assert property (@(posedge clk) disable iff (rst)
        (aop == ALU_SLT) |-> (alu_y[XLEN-1:1] == '0));

    // R7: a branch never writes the register file
    p_branch_no_wb_r7: assert property (@(posedge clk) disable iff (rst)
        ctl.is_branch |-> !ctl.rf_we);

endmodule

// File: tb/scp_core_bench.sv
`timescale 1ns/1ps
module scp_core_bench;

    localparam int AW    = 10;
    localparam int NCYC  = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pl_imem_we = 1'b0, pl_dmem_we = 1'b0;
    logic [31:0] pl_addr = '0, pl_data = '0;
    logic [4:0]  dbg_reg_sel = '0;
    logic [31:0] dbg_mem_addr = '0;
    logic [31:0] dbg_pc, dbg_reg_data, dbg_mem_data;

    scp_core #(.MEM_AW(AW)) u_scp_core (
        .clk(clk), .rst(rst),
        .pl_imem_we(pl_imem_we), .pl_dmem_we(pl_dmem_we),
        .pl_addr(pl_addr), .pl_data(pl_data),
        .dbg_reg_sel(dbg_reg_sel), .dbg_mem_addr(dbg_mem_addr),
        .dbg_pc(dbg_pc), .dbg_reg_data(dbg_reg_data), .dbg_mem_data(dbg_mem_data)
    );

    always #5 clk = ~clk;

    int  n_chk = 0, n_fail = 0;
    bit  done = 1'b0;

    logic [31:0] prog [0:255];
    int          plen = 0;
    logic [31:0] m_reg [0:31];
    logic [31:0] m_mem [0:(1<<AW)-1];
    logic [31:0] m_pc;
    string       m_tag [0:31];

    // per-step observation plan
    string       s_pc_tag, s_reg_tag;
    int          s_reg;
    bit          s_st;
    logic [31:0] s_st_addr;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'b00000, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic emit(input logic [31:0] w);
        prog[plen] = w;
        plen++;
    endtask

    // reference model of one instruction, taken from the requirements
    task automatic m_step();
        logic [31:0] w, a, b, sx, v, nxt, ad;
        int rs, rt, rd, d;
        bit wr;
        w   = prog[m_pc[9:2]];
        rs  = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
        sx  = {{16{w[15]}}, w[15:0]};
        a   = m_reg[rs]; b = m_reg[rt];
        nxt = m_pc + 32'd4;
        wr = 1'b0; d = rt; v = '0;
        s_pc_tag = "R1"; s_reg = -1; s_st = 1'b0; s_reg_tag = "R3";
        case (w[31:26])
            6'h00: begin
                wr = 1'b1; d = rd; s_reg_tag = "R3";
                case (w[5:0])
                    6'h20: v = a + b;
                    6'h22: v = a - b;
                    6'h24: v = a & b;
                    6'h25: v = a | b;
                    6'h2a: begin v = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; s_reg_tag = "R5"; end
                    default: v = a + b;
                endcase
            end
            6'h08: begin wr = 1'b1; v = a + sx; s_reg_tag = "R4"; end
            6'h0c: begin wr = 1'b1; v = a & sx; s_reg_tag = "R4"; end
            6'h0d: begin wr = 1'b1; v = a | sx; s_reg_tag = "R4"; end
            6'h0a: begin wr = 1'b1; v = ($signed(a) < $signed(sx)) ? 32'd1 : 32'd0; s_reg_tag = "R5"; end
            6'h23: begin
                ad = a + sx; wr = 1'b1; v = m_mem[ad[AW+1:2]]; s_reg_tag = "R6";
            end
            6'h2b: begin
                ad = a + sx; m_mem[ad[AW+1:2]] = b; s_st = 1'b1; s_st_addr = ad;
            end
            6'h04: begin
                s_pc_tag = "R7";
                if (a == b) nxt = m_pc + 32'd4 + {sx[29:0], 2'b00};
                s_reg = rt; s_reg_tag = "R7";
            end
            default: begin
                s_pc_tag = "R9"; s_reg = rt; s_reg_tag = "R9";
            end
        endcase
        if (wr) begin
            s_reg = d;
            if (d == 0) s_reg_tag = "R8";
            else begin m_reg[d] = v; m_tag[d] = s_reg_tag; end
        end
        m_pc = nxt;
    endtask

    task automatic build_prog();
        logic [15:0] lf, va, vb;
        logic [5:0]  fns [5];
        logic [5:0]  iops [4];
        fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2a;
        iops[0] = 6'h08; iops[1] = 6'h0c; iops[2] = 6'h0d; iops[3] = 6'h0a;
        for (int i = 0; i < 256; i++) prog[i] = '0;
        emit(enc_i(6'h08, 0, 1, 16'h1234));
        emit(enc_i(6'h08, 0, 2, 16'hFFFB));
        emit(enc_i(6'h0d, 0, 3, 16'h8001));
        emit(enc_i(6'h0c, 1, 4, 16'h00F0));
        emit(enc_i(6'h0a, 2, 5, 16'h0003));
        emit(enc_i(6'h0a, 1, 6, 16'hFFFF));
        emit(enc_r(6'h20, 1, 2, 7));
        emit(enc_r(6'h22, 2, 1, 8));
        emit(enc_r(6'h24, 1, 3, 9));
        emit(enc_r(6'h25, 1, 2, 10));
        emit(enc_r(6'h2a, 2, 1, 11));
        emit(enc_r(6'h2a, 1, 2, 12));
        emit(enc_i(6'h08, 0, 0, 16'h0007));
        emit(enc_r(6'h20, 1, 1, 0));
        emit(enc_i(6'h2b, 0, 7, 16'h0008));
        emit(enc_i(6'h2b, 0, 2, 16'h000C));
        emit(enc_i(6'h23, 0, 13, 16'h0008));
        emit(enc_i(6'h23, 0, 14, 16'h000C));
        emit(enc_i(6'h23, 0, 17, 16'h0100));
        emit(enc_i(6'h3f, 1, 25, 16'h0001));
        emit(enc_i(6'h02, 1, 25, 16'h0040));
        emit(enc_i(6'h04, 1, 2, 16'h0002));
        emit(enc_i(6'h04, 7, 13, 16'h0001));
        emit(enc_i(6'h08, 0, 15, 16'h0001));
        emit(enc_i(6'h08, 0, 16, 16'h0002));
        lf = 16'hACE1;
        for (int k = 0; k < 16; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            va = lf;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            vb = (k % 4 == 0) ? va : lf;
            emit(enc_i(6'h08, 0, 18, va));
            emit(enc_i(6'h08, 0, 19, vb));
            emit(enc_r(fns[k % 5], 18, 19, 20 + (k % 5)));
            emit(enc_r(6'h2a, 19, 18, 28));
            emit(enc_i(iops[k % 4], 18, 26, vb));
            emit(enc_i(6'h2b, 0, 20 + (k % 5), 16'(32'h40 + 4 * k)));
            emit(enc_i(6'h23, 0, 29, 16'(32'h40 + 4 * k)));
            emit(enc_i(6'h04, 18, 19, 16'h0001));
            emit(enc_i(6'h08, 27, 27, 16'h0001));
        end
        emit(enc_i(6'h04, 0, 0, 16'hFFFF));
    endtask

    initial begin
        build_prog();
        for (int i = 0; i < 32; i++) begin m_reg[i] = '0; m_tag[i] = "R1"; end
        for (int i = 0; i < (1 << AW); i++) m_mem[i] = '0;
        m_tag[25] = "R9";
        m_pc = '0;

        // preload while reset is held (R10)
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            pl_imem_we = 1'b1; pl_addr = 32'(4 * i); pl_data = prog[i];
        end
        @(negedge clk);
        pl_imem_we = 1'b0;
        pl_dmem_we = 1'b1; pl_addr = 32'h100; pl_data = 32'hCAFEF00D;
        m_mem[32'h100 >> 2] = 32'hCAFEF00D;
        @(negedge clk);
        pl_dmem_we = 1'b0;
        @(negedge clk);

        // reset state (R1) and preload readback (R10)
        check("R1", "pc in reset", dbg_pc, 32'h0);
        for (int r = 0; r < 32; r++) begin
            dbg_reg_sel = 5'(r); #1;
            check("R1", $sformatf("reg %0d after reset", r), dbg_reg_data, 32'h0);
        end
        dbg_mem_addr = 32'h100; #1;
        check("R10", "preloaded data word", dbg_mem_data, 32'hCAFEF00D);
        dbg_reg_sel = 5'd0; #1;
        rst = 1'b0;

        for (int c = 0; c < NCYC; c++) begin
            m_step();
            @(negedge clk);
            check(s_pc_tag, $sformatf("pc after cycle %0d", c), dbg_pc, m_pc);
            if (s_reg >= 0) begin
                dbg_reg_sel = 5'(s_reg); #1;
                check(s_reg_tag, $sformatf("reg %0d after cycle %0d", s_reg, c),
                      dbg_reg_data, (s_reg == 0) ? 32'h0 : m_reg[s_reg]);
            end
            if (s_st) begin
                dbg_mem_addr = s_st_addr; #1;
                check("R6", $sformatf("store at %h", s_st_addr), dbg_mem_data,
                      m_mem[s_st_addr[AW+1:2]]);
            end
        end

        // final register image
        for (int r = 0; r < 32; r++) begin
            dbg_reg_sel = 5'(r); #1;
            check((r == 0) ? "R8" : m_tag[r], $sformatf("final reg %0d", r),
                  dbg_reg_data, m_reg[r]);
        end
        check("R7", "skipped instruction left reg 15", m_reg[15], 32'h0);
        dbg_reg_sel = 5'd17; #1;
        check("R10", "load of preloaded word", dbg_reg_data, 32'hCAFEF00D);
        dbg_mem_addr = 32'h8; #1;
        check("R6", "stored sum", dbg_mem_data, 32'h0000122F);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule